// File: doc/BRIEF.md
# Descriptor Ring DMA Channel

This block is one DMA channel that services a circular ring of descriptors kept in a small local memory. Each descriptor takes two 32-bit words. The even word holds a buffer word address. The odd word holds the status: an ownership flag, packet-boundary flags, a completion flag, a byte offset and a length. Software fills in descriptors through a word-wide memory port and hands each one to the engine by setting its ownership bit. It then sets the ring base and the ring length, and raises the enable.

The engine fetches the descriptor at the current ring position. When the engine owns it, the engine moves the payload through a ready/valid stream. At build time a parameter selects the direction: transmit, which emits beats, or receive, which accepts beats. When the transfer is done, the engine writes the status word back with ownership returned to software and the completion flag set. It then steps to the next ring position. When a descriptor is still owned by software, the channel waits a fixed poll interval and fetches the same descriptor again. It never skips ahead.

Top module: `dring_dma`

## Requirements
- R1: After reset, `busy`, `out_valid`, `in_ready` and `rx_good` are all low.
- R2: A descriptor whose status bit 31 (ownership) is 0 causes no stream beat and no write-back. The engine fetches the same descriptor again every `POLL_CYC` cycles and processes it once software sets bit 31.
- R3: In transmit mode, a descriptor produces ceil((offset + length) / 4) beats. The offset is status bits 26:23 and the length is status bits 15:0, in bytes. Beat k carries address pointer + 4k on `beat_addr`. `out_last` is high only on the final beat.
- R4: Transmit write-back clears bit 31, sets bit 28 (completion) and keeps every other status bit, including bit 30 (start of packet) and bit 29 (end of packet).
- R5: In receive mode, the engine accepts beats until a beat with `in_last` arrives or until length/4 beats have been taken. It writes back bit 31 = 0, bit 30 = 1, bit 29 = 1 only if `in_last` ended the transfer, bit 28 = 1, the offset unchanged, and length = beats × 4.
- R6: In receive mode, `rx_good` pulses for one cycle at write-back only when the written length is below 1536 bytes.
- R7: The ring position starts at the base, steps by one after each write-back, and wraps to the base after `ring_len` descriptors.
- R8: When the enable is cleared, the current descriptor still finishes. `busy` then falls at the next descriptor boundary or poll point. While idle and disabled, the position returns to the base.
- R9: When a software write hits the same word as an engine write-back in the same cycle, the engine's value is stored.
- R10: A descriptor with a beat count of zero completes and is written back without any stream beat.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid`, `beat_addr` and `out_last` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_en | input | 1 | Channel enable |
| ring_base | input | IDX_W | First descriptor of the ring |
| ring_len | input | IDX_W+1 | Number of descriptors in the ring |
| busy | output | 1 | Engine not idle |
| sw_addr | input | IDX_W+1 | Software word address (descriptor × 2 + word) |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Word at `sw_addr`, combinational |
| out_valid | output | 1 | Transmit beat valid |
| out_ready | input | 1 | Transmit beat accepted |
| out_last | output | 1 | Final transmit beat of a descriptor |
| in_valid | input | 1 | Receive beat valid |
| in_ready | output | 1 | Receive beat accepted |
| in_last | input | 1 | Receive beat ends the packet |
| beat_addr | output | 32 | Buffer address of the current beat |
| rx_good | output | 1 | Receive descriptor completed below the length limit |

## Verification
The engine's status write-back and a software store can hit the same descriptor word in the same cycle. The bench provokes this with the stream held ready. It watches for the final beat of a one-beat descriptor, then issues a software write of garbage to that descriptor's status word exactly one cycle later, which is the write-back cycle. The word read back afterwards must equal the engine's completed status, not the garbage. The bench also runs software re-arming a descriptor while the engine polls it, and checks that the stream order proves nothing was skipped.

// File: rtl/dring_pkg.sv
package dring_pkg;
  localparam int OWN_B  = 31;
  localparam int SOP_B  = 30;
  localparam int EOP_B  = 29;
  localparam int CMP_B  = 28;
  localparam int OFS_LO = 23;
  localparam int OFS_W  = 4;
  localparam int LEN_W  = 16;

  typedef enum logic [2:0] {
    S_IDLE, S_PTR, S_STAT, S_MOVE, S_WB, S_POLL
  } eng_st_e;
endpackage

// File: rtl/dring_mem.sv
module dring_mem #(
  parameter int WORDS = 64,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] e_addr,
  input  logic          e_we,
  input  logic [31:0]   e_wdata,
  output logic [31:0]   e_rdata,
  input  logic [AW-1:0] s_addr,
  input  logic          s_we,
  input  logic [31:0]   s_wdata,
  output logic [31:0]   s_rdata
);
  logic [31:0] mem [WORDS];
  logic        s_blocked;

  assign s_blocked = e_we && (e_addr == s_addr);
  assign e_rdata   = mem[e_addr];
  assign s_rdata   = mem[s_addr];

  always_ff @(posedge clk) begin
    if (e_we) mem[e_addr] <= e_wdata;
    if (s_we && !s_blocked) mem[s_addr] <= s_wdata;
  end

  // R9: the engine write lands even under a colliding software store
  a_r9_engine_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    e_we |=> (mem[$past(e_addr)] == $past(e_wdata)));
endmodule

// File: rtl/dring_idx.sv
module dring_idx #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [IDX_W-1:0] ring_base,
  input  logic [IDX_W:0]   ring_len,
  output logic [IDX_W-1:0] slot
);
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W:0]   nxt;

  assign nxt  = {1'b0, idx_q} + {{IDX_W{1'b0}}, 1'b1};
  assign slot = ring_base + idx_q;

  always_comb begin
    idx_d = idx_q;
    if (clr)      idx_d = '0;
    else if (adv) idx_d = (nxt >= ring_len) ? '0 : nxt[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  // R7: after a step the position lies inside the ring
  a_r7_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && ring_len != '0) |=> ({1'b0, idx_q} < $past(ring_len)));
endmodule

// File: rtl/dring_engine.sv
module dring_engine
  import dring_pkg::*;
#(
  parameter int TX_MODE   = 1,
  parameter int IDX_W     = 5,
  parameter int AW        = 6,
  parameter int POLL_CYC  = 8,
  parameter int LEN_LIMIT = 1536
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [IDX_W-1:0] slot,
  output logic             adv,
  output logic             clr,
  output logic [AW-1:0]    m_addr,
  output logic             m_we,
  output logic [31:0]      m_wdata,
  input  logic [31:0]      m_rdata,
  output logic             busy,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_last,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_last,
  output logic [31:0]      beat_addr,
  output logic             rx_good
);
  localparam bit IS_TX = (TX_MODE != 0);
  localparam int CW    = LEN_W + 1;
  localparam int PW    = $clog2(POLL_CYC + 1);

  eng_st_e         st_q, st_d;
  logic [31:0]     ptr_q, ptr_d, stat_q, stat_d;
  logic [CW-1:0]   beat_q, beat_d, need_q, need_d, need_new;
  logic            eop_q, eop_d;
  logic [PW-1:0]   poll_q, poll_d;
  logic            xfer, last_beat;
  logic [31:0]     wb_word;
  logic [CW+1:0]   byte_cnt;

  assign last_beat = (beat_q + CW'(1)) == need_q;
  assign byte_cnt  = {beat_q, 2'b00};

  generate
    if (IS_TX) begin : g_tx
      logic [CW-1:0] span;
      assign span     = CW'(m_rdata[LEN_W-1:0]) + CW'(m_rdata[OFS_LO+OFS_W-1:OFS_LO]) + CW'(3);
      assign need_new = span >> 2;
      assign xfer     = out_ready;
      assign wb_word  = {1'b0, stat_q[SOP_B:EOP_B], 1'b1, stat_q[CMP_B-1:0]};
    end else begin : g_rx
      assign need_new = CW'(m_rdata[LEN_W-1:2]);
      assign xfer     = in_valid;
      assign wb_word  = {1'b0, 1'b1, eop_q, 1'b1, stat_q[CMP_B-1:LEN_W], beat_q[LEN_W-3:0], 2'b00};
    end
  endgenerate

  always_comb begin
    st_d   = st_q;
    ptr_d  = ptr_q;
    stat_d = stat_q;
    beat_d = beat_q;
    need_d = need_q;
    eop_d  = eop_q;
    poll_d = poll_q;
    case (st_q)
      S_IDLE: if (en) st_d = S_PTR;
      S_PTR: begin
        ptr_d = m_rdata;
        st_d  = S_STAT;
      end
      S_STAT: begin
        stat_d = m_rdata;
        beat_d = '0;
        eop_d  = 1'b0;
        need_d = need_new;
        if (!m_rdata[OWN_B]) begin
          st_d   = S_POLL;
          poll_d = PW'(POLL_CYC - 1);
        end else if (need_new == '0) begin
          st_d = S_WB;
        end else begin
          st_d = S_MOVE;
        end
      end
      S_MOVE: if (xfer) begin
        beat_d = beat_q + CW'(1);
        if (last_beat || (!IS_TX && in_last)) begin
          st_d  = S_WB;
          eop_d = !IS_TX && in_last;
        end
      end
      S_WB: st_d = en ? S_PTR : S_IDLE;
      S_POLL: begin
        if (!en)                st_d = S_IDLE;
        else if (poll_q == '0)  st_d = S_PTR;
        else                    poll_d = poll_q - PW'(1);
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      ptr_q  <= '0;
      stat_q <= '0;
      beat_q <= '0;
      need_q <= '0;
      eop_q  <= 1'b0;
      poll_q <= '0;
    end else begin
      st_q   <= st_d;
      ptr_q  <= ptr_d;
      stat_q <= stat_d;
      beat_q <= beat_d;
      need_q <= need_d;
      eop_q  <= eop_d;
      poll_q <= poll_d;
    end
  end

  assign busy      = (st_q != S_IDLE);
  assign m_addr    = {slot, (st_q != S_PTR)};
  assign m_we      = (st_q == S_WB);
  assign m_wdata   = wb_word;
  assign adv       = (st_q == S_WB);
  assign clr       = (st_q == S_IDLE) && !en;
  assign out_valid = IS_TX && (st_q == S_MOVE);
  assign out_last  = out_valid && last_beat;
  assign in_ready  = !IS_TX && (st_q == S_MOVE);
  assign beat_addr = ptr_q + {{(30-CW){1'b0}}, beat_q, 2'b00};
  assign rx_good   = !IS_TX && (st_q == S_WB) && (byte_cnt < (CW+2)'(LEN_LIMIT));

  // R11: an offered beat stays put until taken
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(beat_addr) && $stable(out_last)));
  // R3: no transmit beat beyond the computed count
  a_r3_beat_bound: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (beat_q < need_q));
  // R5: receive never takes more than the buffer holds
  a_r5_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (beat_q < need_q));
  // R6: the good pulse lasts one cycle
  a_r6_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_good |=> !rx_good);
  // R8: disabled and idle stays idle
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !en) |=> !busy);
endmodule

// File: rtl/dring_dma.sv
module dring_dma #(
  parameter int DESC_CNT  = 32,
  parameter int TX_MODE   = 1,
  parameter int POLL_CYC  = 8,
  parameter int LEN_LIMIT = 1536,
  localparam int IDX_W    = $clog2(DESC_CNT),
  localparam int AW       = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ring_en,
  input  logic [IDX_W-1:0] ring_base,
  input  logic [IDX_W:0]   ring_len,
  output logic             busy,
  input  logic [AW-1:0]    sw_addr,
  input  logic             sw_we,
  input  logic [31:0]      sw_wdata,
  output logic [31:0]      sw_rdata,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_last,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_last,
  output logic [31:0]      beat_addr,
  output logic             rx_good
);
  logic [1:0]       rs_q;
  logic             rst_core_n;
  logic             adv, clr, m_we;
  logic [IDX_W-1:0] slot;
  logic [AW-1:0]    m_addr;
  logic [31:0]      m_wdata, m_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  dring_mem #(.WORDS(2 * DESC_CNT), .AW(AW)) u_mem (
    .clk(clk), .rst_n(rst_core_n),
    .e_addr(m_addr), .e_we(m_we), .e_wdata(m_wdata), .e_rdata(m_rdata),
    .s_addr(sw_addr), .s_we(sw_we), .s_wdata(sw_wdata), .s_rdata(sw_rdata)
  );

  dring_idx #(.IDX_W(IDX_W)) u_idx (
    .clk(clk), .rst_n(rst_core_n), .clr(clr), .adv(adv),
    .ring_base(ring_base), .ring_len(ring_len), .slot(slot)
  );

  dring_engine #(
    .TX_MODE(TX_MODE), .IDX_W(IDX_W), .AW(AW),
    .POLL_CYC(POLL_CYC), .LEN_LIMIT(LEN_LIMIT)
  ) u_eng (
    .clk(clk), .rst_n(rst_core_n), .en(ring_en), .slot(slot),
    .adv(adv), .clr(clr),
    .m_addr(m_addr), .m_we(m_we), .m_wdata(m_wdata), .m_rdata(m_rdata),
    .busy(busy),
    .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
    .in_valid(in_valid), .in_ready(in_ready), .in_last(in_last),
    .beat_addr(beat_addr), .rx_good(rx_good)
  );
endmodule

// File: tb/dring_dma_tb.sv
`timescale 1ns/1ps
module dring_dma_tb;
  localparam int PC = 8;

  logic clk, rst_n;
  int total, bad, cyc;
  bit finished;

  // transmit instance
  logic        t_en, t_busy, t_we, t_valid, t_ready, t_last, t_good, t_inr;
  logic [4:0]  t_base;
  logic [5:0]  t_len, t_addr;
  logic [31:0] t_wdata, t_rdata, t_baddr;
  // receive instance
  logic        r_en, r_busy, r_we, r_ovalid, r_ivalid, r_iready, r_ilast, r_olast, r_good;
  logic [4:0]  r_base;
  logic [5:0]  r_len, r_addr;
  logic [31:0] r_wdata, r_rdata, r_baddr;

  dring_dma #(.TX_MODE(1), .POLL_CYC(PC)) u_dut (
    .clk(clk), .rst_n(rst_n), .ring_en(t_en), .ring_base(t_base), .ring_len(t_len),
    .busy(t_busy), .sw_addr(t_addr), .sw_we(t_we), .sw_wdata(t_wdata), .sw_rdata(t_rdata),
    .out_valid(t_valid), .out_ready(t_ready), .out_last(t_last),
    .in_valid(1'b0), .in_ready(t_inr), .in_last(1'b0),
    .beat_addr(t_baddr), .rx_good(t_good));

  dring_dma #(.TX_MODE(0), .POLL_CYC(PC)) u_dut_rx (
    .clk(clk), .rst_n(rst_n), .ring_en(r_en), .ring_base(r_base), .ring_len(r_len),
    .busy(r_busy), .sw_addr(r_addr), .sw_we(r_we), .sw_wdata(r_wdata), .sw_rdata(r_rdata),
    .out_valid(r_ovalid), .out_ready(1'b0), .out_last(r_olast),
    .in_valid(r_ivalid), .in_ready(r_iready), .in_last(r_ilast),
    .beat_addr(r_baddr), .rx_good(r_good));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit own, input bit sop, input bit eop, input bit cmp,
                                     input logic [3:0] off, input logic [15:0] len);
    return {own, sop, eop, cmp, 1'b0, off, 7'b0, len};
  endfunction

  // reference model of the transmit stream
  logic [32:0] tq[$];
  bit          rdy_all, prev_stall, mon_on;
  logic [32:0] prev_beat;
  int          hs_cnt, good_cnt;

  always @(posedge clk) t_ready <= rdy_all || (cyc % 3 != 0);

  always @(negedge clk) begin
    if (mon_on) begin
      if (prev_stall)
        chk(t_valid && {t_last, t_baddr} == prev_beat, "R11 hold", {t_valid, t_baddr[30:0]}, prev_beat[31:0]);
      if (t_valid && t_ready) begin
        hs_cnt++;
        if (tq.size() == 0) chk(1'b0, "R3 unexpected beat", t_baddr, 32'h0);
        else begin
          logic [32:0] e;
          e = tq.pop_front();
          chk({t_last, t_baddr} == e, "R3 beat", {t_last, t_baddr[30:0]}, {e[32], e[30:0]});
        end
      end
      prev_stall = t_valid && !t_ready;
      prev_beat  = {t_last, t_baddr};
      if (r_good) good_cnt++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=hang exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tw(input int a, input logic [31:0] d);
    @(negedge clk); t_addr = 6'(a); t_wdata = d; t_we = 1'b1;
    @(negedge clk); t_we = 1'b0;
  endtask
  task automatic rw(input int a, input logic [31:0] d);
    @(negedge clk); r_addr = 6'(a); r_wdata = d; r_we = 1'b1;
    @(negedge clk); r_we = 1'b0;
  endtask
  task automatic twait(input int a, output logic [31:0] d);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk); t_addr = 6'(a); #1 d = t_rdata;
      if (!d[31]) break;
    end
  endtask
  task automatic rwait(input int a, output logic [31:0] d);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk); r_addr = 6'(a); #1 d = r_rdata;
      if (!d[31]) break;
    end
  endtask
  task automatic tread(input int a, output logic [31:0] d);
    @(negedge clk); t_addr = 6'(a); #1 d = t_rdata;
  endtask
  task automatic push(input logic [31:0] ptr, input int beats);
    for (int k = 0; k < beats; k++) tq.push_back({k == beats - 1, ptr + 32'(4 * k)});
  endtask
  task automatic t_off_wait();
    t_en = 1'b0;
    for (int i = 0; i < PC + 8; i++) begin
      @(negedge clk);
      if (!t_busy) break;
    end
  endtask
  task automatic rx_send(input logic [31:0] ptr, input int n, input bit last);
    for (int k = 0; k < n; k++) begin
      r_ivalid = 1'b1; r_ilast = last && (k == n - 1);
      while (!r_iready) @(negedge clk);
      chk(r_baddr == ptr + 32'(4 * k), "R5 rx beat address", r_baddr, ptr + 32'(4 * k));
      @(negedge clk);
    end
    r_ivalid = 1'b0; r_ilast = 1'b0;
  endtask

  initial begin
    logic [31:0] d;
    int hs0, g0;
    total = 0; bad = 0; cyc = 0; finished = 0; mon_on = 0; rdy_all = 0;
    hs_cnt = 0; good_cnt = 0; prev_stall = 0; prev_beat = '0;
    t_en = 0; t_base = 0; t_len = 0; t_addr = 0; t_we = 0; t_wdata = 0;
    r_en = 0; r_base = 0; r_len = 0; r_addr = 0; r_we = 0; r_wdata = 0;
    r_ivalid = 0; r_ilast = 0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1;

    // R1 reset state
    chk(!t_busy && !t_valid && !t_good, "R1 tx idle", {t_busy, t_valid, t_good}, 0);
    chk(!r_busy && !r_iready && !r_good, "R1 rx idle", {r_busy, r_iready, r_good}, 0);

    // transmit ring: slots 4..6
    tw(8,  32'h1000); tw(9,  mk(1,1,1,0,0,8));
    tw(10, 32'h2000); tw(11, mk(1,1,1,0,4,13));
    tw(12, 32'h3000); tw(13, mk(1,1,1,0,0,0));
    push(32'h1000, 2); push(32'h2000, 5);
    t_base = 5'd4; t_len = 6'd3; t_en = 1'b1;
    twait(13, d);
    chk(d == mk(0,1,1,1,0,0), "R10 zero-beat writeback", d, mk(0,1,1,1,0,0));
    tread(9, d);  chk(d == mk(0,1,1,1,0,8), "R4 writeback slot4", d, mk(0,1,1,1,0,8));
    tread(11, d); chk(d == mk(0,1,1,1,4,13), "R4 writeback slot5", d, mk(0,1,1,1,4,13));
    chk(tq.size() == 0, "R3 all beats seen", tq.size(), 0);

    // R7 wrap back to the base slot
    tw(8, 32'h4000); tw(9, mk(1,1,1,0,0,4));
    push(32'h4000, 1);
    twait(9, d);
    chk(d == mk(0,1,1,1,0,4) && tq.size() == 0, "R7 wrap to base", d, mk(0,1,1,1,0,4));

    // R8 disable stops at a boundary
    t_off_wait();
    chk(!t_busy, "R8 busy falls", t_busy, 0);
    repeat (10) @(negedge clk);
    chk(!t_busy, "R8 stays idle", t_busy, 0);

    // R2 stall on an unowned descriptor, position restarted at base (R8)
    tw(10, 32'h6000); tw(11, mk(1,1,1,0,0,4));
    hs0 = hs_cnt;
    t_en = 1'b1;
    repeat (40) @(negedge clk);
    tread(11, d);
    chk(hs_cnt == hs0 && d[31], "R2 stall no skip", hs_cnt - hs0, 0);
    tw(8, 32'h7000); tw(9, mk(1,1,1,0,0,8));
    push(32'h7000, 2); push(32'h6000, 1);
    twait(11, d);
    chk(tq.size() == 0 && d == mk(0,1,1,1,0,4), "R2 picked up after rearm", d, mk(0,1,1,1,0,4));
    t_off_wait();

    // R9 collision of write-back and software store
    rdy_all = 1;
    tw(20, 32'h5000); tw(21, mk(1,1,1,0,0,4));
    push(32'h5000, 1);
    t_base = 5'd10; t_len = 6'd1; t_en = 1'b1;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (t_valid) break;
    end
    @(negedge clk); t_addr = 6'd21; t_wdata = 32'hDEADBEEF; t_we = 1'b1;
    @(negedge clk); t_we = 1'b0;
    tread(21, d);
    chk(d == mk(0,1,1,1,0,4), "R9 engine wins", d, mk(0,1,1,1,0,4));
    t_off_wait();
    rdy_all = 0;

    // receive ring: slots 0..1
    rw(0, 32'h100); rw(1, mk(1,0,0,0,2,16));
    rw(2, 32'h200); rw(3, mk(1,0,0,0,0,8));
    r_base = 5'd0; r_len = 6'd2; r_en = 1'b1;
    g0 = good_cnt;
    rx_send(32'h100, 3, 1);
    rwait(1, d);
    chk(d == mk(0,1,1,1,2,12), "R5 ended by last", d, mk(0,1,1,1,2,12));
    chk(good_cnt == g0 + 1, "R6 good pulse short", good_cnt - g0, 1);
    rx_send(32'h200, 2, 0);
    rwait(3, d);
    chk(d == mk(0,1,0,1,0,8), "R5 ended by capacity", d, mk(0,1,0,1,0,8));
    chk(good_cnt == g0 + 2, "R6 good pulse capacity", good_cnt - g0, 2);
    rw(0, 32'h8000); rw(1, mk(1,0,0,0,0,1536));
    rx_send(32'h8000, 384, 0);
    rwait(1, d);
    chk(d == mk(0,1,0,1,0,1536), "R7 rx wrap and R5 length", d, mk(0,1,0,1,0,1536));
    chk(good_cnt == g0 + 2, "R6 no pulse at 1536", good_cnt - g0, 2);
    rw(2, 32'h9000); rw(3, mk(1,0,0,0,0,1532));
    rx_send(32'h9000, 383, 0);
    rwait(3, d);
    chk(d == mk(0,1,0,1,0,1532), "R5 length 1532", d, mk(0,1,0,1,0,1532));
    chk(good_cnt == g0 + 3, "R6 pulse at 1532", good_cnt - g0, 3);
    r_en = 1'b0;
    repeat (PC + 6) @(negedge clk);
    chk(!r_busy, "R8 rx stops", r_busy, 0);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule